// File: doc/BRIEF.md
# Dual-Port Semaphore Unit

This block holds a small bank of hardware ownership tokens that two independent ports, called left and right, use to coordinate access to a shared resource. Each token is either free or held by exactly one port. A port asks for a token by writing a 0 to it and gives it back by writing a 1. A port checks whether it holds a token by reading it. A read returns 0 when the reading port holds the token and 1 in every other case. Token accesses use a select line of their own, apart from any memory enable.

A request made while the other port holds the token is not lost. It stays pending, and the token passes to the waiting port in the same cycle that the holder releases it. A waiting port withdraws its request by writing a 1 before the token reaches it. When both ports ask for the same free token in the same cycle, left takes it and right's request waits.

All inputs are sampled on one clock edge. Read data is registered and appears one cycle after the read. The output keeps its value while that port is not reading. The reset input is asynchronous, active low, and its release is synchronised inside the block.

Top module: `dps_sema_unit`

## Requirements
- R1: At no time do both ports hold the same token.
- R2: A write of data 0 to a free token gives it to the writing port, and the grant is visible to a read issued on the next cycle.
- R3: While one port holds a token, writes from the other port do not change who holds it. A 0 from the other port only queues a request, and a 1 only withdraws one.
- R4: After reset every token is free, both read outputs are 1, and a read of a free token returns 1 on both ports.
- R5: A read returns 0 to the port that holds the token and 1 to the other port.
- R6: A write of data 1 by the holder frees the token when no request from the other port is waiting.
- R7: When the holder releases a token that the other port has requested, that port holds the token from the next cycle on. A request made in the same cycle as the release counts as waiting.
- R8: When both ports write 0 to the same free token in the same cycle, left gets it and right's request waits.
- R9: A waiting port that writes 1 to the token before the grant withdraws its request, so a later release leaves the token free.
- R10: There are eight tokens. Each is chosen by address bits [2:0]. Upper address bits are ignored, and an access to one token never changes another.
- R11: With the port's select input low, that port's write and read inputs have no effect.
- R12: Read data appears on the port output one cycle after a read (select high, write-enable low) and holds its value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| lft_sel_i | input | 1 | Left token select, active high |
| lft_wr_i | input | 1 | Left write enable (1 write, 0 read) |
| lft_addr_i | input | ADDR_W | Left address; bits [2:0] pick the token |
| lft_din_i | input | 1 | Left write data: 0 request, 1 release |
| lft_dout_o | output | 1 | Left read data: 0 when left holds the token |
| rgt_sel_i | input | 1 | Right token select, active high |
| rgt_wr_i | input | 1 | Right write enable (1 write, 0 read) |
| rgt_addr_i | input | ADDR_W | Right address; bits [2:0] pick the token |
| rgt_din_i | input | 1 | Right write data: 0 request, 1 release |
| rgt_dout_o | output | 1 | Right read data: 0 when right holds the token |

## Verification
The hardest states to reach from the ports are the ones with a hidden waiting request. A token must be held by one port, the other port must have requested it, and then a release, a withdrawal or a same-cycle release-and-request must happen before anyone reads. Directed sequences build each of these cases step by step: a tie on a free token, a handoff on release, and a withdrawal followed by release. A long random phase then has both ports aim at a small address range, with upper address bits set, so that collisions and queued requests happen often. A bench model tracks the waiting flags and predicts every read.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    TOK_FREE  = 2'd0,
    TOK_LEFT  = 2'd1,
    TOK_RIGHT = 2'd2
  } tok_owner_e;

endpackage

// File: rtl/dps_rst_sync.sv
module dps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dps_port_decode.sv
module dps_port_decode #(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = 8,
  localparam int SEL_W   = $clog2(NUM_SEMA)
) (
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                din_i,
  output logic [NUM_SEMA-1:0] take_o,
  output logic [NUM_SEMA-1:0] drop_o,
  output logic                rd_o,
  output logic [SEL_W-1:0]    idx_o
);

  logic wr_go;

  assign wr_go = sel_i & wr_i;
  assign rd_o  = sel_i & ~wr_i;
  assign idx_o = addr_i[SEL_W-1:0];

  generate
    if (ADDR_W > SEL_W) begin : g_hi
      logic addr_hi_unused;
      assign addr_hi_unused = ^addr_i[ADDR_W-1:SEL_W];
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_SEMA; i++) begin : g_hit
      logic hit;
      assign hit       = wr_go & (idx_o == SEL_W'(i));
      assign take_o[i] = hit & ~din_i;
      assign drop_o[i] = hit & din_i;
    end
  endgenerate

endmodule

// File: rtl/dps_sema_cell.sv
module dps_sema_cell
  import dps_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic l_take_i,
  input  logic l_drop_i,
  input  logic r_take_i,
  input  logic r_drop_i,
  output logic own_l_o,
  output logic own_r_o
);

  tok_owner_e owner_q, owner_d;
  logic       wait_l_q, wait_l_d;
  logic       wait_r_q, wait_r_d;
  logic       upd_en;
  logic       wait_l_eff, wait_r_eff;

  assign upd_en     = l_take_i | l_drop_i | r_take_i | r_drop_i;
  assign wait_l_eff = (wait_l_q | l_take_i) & ~l_drop_i;
  assign wait_r_eff = (wait_r_q | r_take_i) & ~r_drop_i;

  always_comb begin
    owner_d  = owner_q;
    wait_l_d = wait_l_q;
    wait_r_d = wait_r_q;
    case (owner_q)
      TOK_FREE: begin
        wait_l_d = 1'b0;
        wait_r_d = 1'b0;
        if (l_take_i) begin
          owner_d  = TOK_LEFT;
          wait_r_d = r_take_i;
        end else if (r_take_i) begin
          owner_d  = TOK_RIGHT;
        end
      end
      TOK_LEFT: begin
        wait_l_d = 1'b0;
        if (l_drop_i) begin
          owner_d  = wait_r_eff ? TOK_RIGHT : TOK_FREE;
          wait_r_d = 1'b0;
        end else begin
          wait_r_d = wait_r_eff;
        end
      end
      TOK_RIGHT: begin
        wait_r_d = 1'b0;
        if (r_drop_i) begin
          owner_d  = wait_l_eff ? TOK_LEFT : TOK_FREE;
          wait_l_d = 1'b0;
        end else begin
          wait_l_d = wait_l_eff;
        end
      end
      default: begin
        owner_d  = TOK_FREE;
        wait_l_d = 1'b0;
        wait_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      owner_q  <= TOK_FREE;
      wait_l_q <= 1'b0;
      wait_r_q <= 1'b0;
    end else if (upd_en) begin
      owner_q  <= owner_d;
      wait_l_q <= wait_l_d;
      wait_r_q <= wait_r_d;
    end
  end

  assign own_l_o = (owner_q == TOK_LEFT);
  assign own_r_o = (owner_q == TOK_RIGHT);

endmodule

// File: rtl/dps_read_port.sv
module dps_read_port #(
  parameter int NUM_SEMA = 8,
  localparam int SEL_W   = $clog2(NUM_SEMA)
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                rd_i,
  input  logic [SEL_W-1:0]    idx_i,
  input  logic [NUM_SEMA-1:0] own_vec_i,
  output logic                dout_o
);

  logic dout_q, dout_d;

  always_comb begin
    dout_d = ~own_vec_i[idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dout_q <= 1'b1;
    end else if (rd_i) begin
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/dps_sema_unit.sv
module dps_sema_unit #(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              lft_sel_i,
  input  logic              lft_wr_i,
  input  logic [ADDR_W-1:0] lft_addr_i,
  input  logic              lft_din_i,
  output logic              lft_dout_o,
  input  logic              rgt_sel_i,
  input  logic              rgt_wr_i,
  input  logic [ADDR_W-1:0] rgt_addr_i,
  input  logic              rgt_din_i,
  output logic              rgt_dout_o
);

  localparam int SEL_W = $clog2(NUM_SEMA);

  logic                rst_sync_n;
  logic [NUM_SEMA-1:0] l_take, l_drop, r_take, r_drop;
  logic [NUM_SEMA-1:0] own_l_vec, own_r_vec;
  logic                l_rd, r_rd;
  logic [SEL_W-1:0]    l_idx, r_idx;

  dps_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  dps_port_decode #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W)) u_dec_l (
    .sel_i  (lft_sel_i),
    .wr_i   (lft_wr_i),
    .addr_i (lft_addr_i),
    .din_i  (lft_din_i),
    .take_o (l_take),
    .drop_o (l_drop),
    .rd_o   (l_rd),
    .idx_o  (l_idx)
  );

  dps_port_decode #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W)) u_dec_r (
    .sel_i  (rgt_sel_i),
    .wr_i   (rgt_wr_i),
    .addr_i (rgt_addr_i),
    .din_i  (rgt_din_i),
    .take_o (r_take),
    .drop_o (r_drop),
    .rd_o   (r_rd),
    .idx_o  (r_idx)
  );

  generate
    for (genvar i = 0; i < NUM_SEMA; i++) begin : g_cell
      dps_sema_cell u_cell (
        .clk_i    (clk_i),
        .rst_n_i  (rst_sync_n),
        .l_take_i (l_take[i]),
        .l_drop_i (l_drop[i]),
        .r_take_i (r_take[i]),
        .r_drop_i (r_drop[i]),
        .own_l_o  (own_l_vec[i]),
        .own_r_o  (own_r_vec[i])
      );
    end
  endgenerate

  dps_read_port #(.NUM_SEMA(NUM_SEMA)) u_rd_l (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .rd_i      (l_rd),
    .idx_i     (l_idx),
    .own_vec_i (own_l_vec),
    .dout_o    (lft_dout_o)
  );

  dps_read_port #(.NUM_SEMA(NUM_SEMA)) u_rd_r (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .rd_i      (r_rd),
    .idx_i     (r_idx),
    .own_vec_i (own_r_vec),
    .dout_o    (rgt_dout_o)
  );

endmodule

// File: rtl/dps_sema_chk.sv
module dps_sema_chk #(
  parameter int NUM_SEMA = 8,
  parameter int ADDR_W   = 8,
  localparam int SEL_W   = $clog2(NUM_SEMA)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lft_sel,
  input logic                lft_wr,
  input logic [ADDR_W-1:0]   lft_addr,
  input logic                lft_din,
  input logic                lft_dout,
  input logic                rgt_sel,
  input logic                rgt_wr,
  input logic [ADDR_W-1:0]   rgt_addr,
  input logic                rgt_din,
  input logic                rgt_dout,
  input logic [NUM_SEMA-1:0] own_l,
  input logic [NUM_SEMA-1:0] own_r
);

  logic [SEL_W-1:0] li, ri;
  logic l_wr0, l_wr1, r_wr0, r_wr1, l_rd, r_rd, same_idx;

  assign li       = lft_addr[SEL_W-1:0];
  assign ri       = rgt_addr[SEL_W-1:0];
  assign l_wr0    = lft_sel & lft_wr & ~lft_din;
  assign l_wr1    = lft_sel & lft_wr & lft_din;
  assign r_wr0    = rgt_sel & rgt_wr & ~rgt_din;
  assign r_wr1    = rgt_sel & rgt_wr & rgt_din;
  assign l_rd     = lft_sel & ~lft_wr;
  assign r_rd     = rgt_sel & ~rgt_wr;
  assign same_idx = (li == ri);

  // R1
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R2
  grant_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr0 && !own_l[li] && !own_r[li]) |=> own_l[$past(li)]);

  // R2
  grant_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr0 && !own_l[ri] && !own_r[ri] && !(l_wr0 && same_idx)) |=> own_r[$past(ri)]);

  // R3
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_sel && rgt_wr && own_l[ri] && !(l_wr1 && same_idx)) |=> own_l[$past(ri)]);

  // R6
  release_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr1 && own_l[li]) |=> !own_l[$past(li)]);

  // R8
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr0 && r_wr0 && same_idx && !own_l[li] && !own_r[li]) |=> own_l[$past(li)]);

  // R5
  read_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd |=> (lft_dout == !$past(own_l[li])));

  // R5
  read_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd |=> (rgt_dout == !$past(own_r[ri])));

  // R12
  hold_dout_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(lft_dout));

  // R12
  hold_dout_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(rgt_dout));

  logic r_wr1_used;
  assign r_wr1_used = r_wr1;

endmodule

bind dps_sema_unit dps_sema_chk #(.NUM_SEMA(NUM_SEMA), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_sync_n),
  .lft_sel  (lft_sel_i),
  .lft_wr   (lft_wr_i),
  .lft_addr (lft_addr_i),
  .lft_din  (lft_din_i),
  .lft_dout (lft_dout_o),
  .rgt_sel  (rgt_sel_i),
  .rgt_wr   (rgt_wr_i),
  .rgt_addr (rgt_addr_i),
  .rgt_din  (rgt_din_i),
  .rgt_dout (rgt_dout_o),
  .own_l    (own_l_vec),
  .own_r    (own_r_vec)
);

// File: tb/dps_sema_unit_tb.sv
`timescale 1ns/1ps
module dps_sema_unit_tb;

  logic       clk, rst_n;
  logic       ls, lw, ld, rs, rw, rd;
  logic [7:0] la, ra;
  logic       l_dout, r_dout;

  int n_chk, n_bad;
  bit done;

  int own[8];
  bit pl[8], pr[8];
  logic exp_l, exp_r;

  dps_sema_unit #(.NUM_SEMA(8), .ADDR_W(8)) u_dut (
    .clk_i(clk), .rst_n_i(rst_n),
    .lft_sel_i(ls), .lft_wr_i(lw), .lft_addr_i(la), .lft_din_i(ld), .lft_dout_o(l_dout),
    .rgt_sel_i(rs), .rgt_wr_i(rw), .rgt_addr_i(ra), .rgt_din_i(rd), .rgt_dout_o(r_dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // reference model: 0 free, 1 left, 2 right
  task automatic model_step();
    for (int i = 0; i < 8; i++) begin
      bit lt, ldp, rt, rdp, wl, wr;
      lt  = ls && lw && (la[2:0] == i) && !ld;
      ldp = ls && lw && (la[2:0] == i) && ld;
      rt  = rs && rw && (ra[2:0] == i) && !rd;
      rdp = rs && rw && (ra[2:0] == i) && rd;
      wl  = (pl[i] || lt) && !ldp;
      wr  = (pr[i] || rt) && !rdp;
      case (own[i])
        0: begin
          if (lt) begin own[i] = 1; pr[i] = rt; end
          else if (rt) own[i] = 2;
        end
        1: begin
          if (ldp) begin own[i] = wr ? 2 : 0; pr[i] = 0; end
          else pr[i] = wr;
        end
        default: begin
          if (rdp) begin own[i] = wl ? 1 : 0; pl[i] = 0; end
          else pl[i] = wl;
        end
      endcase
    end
  endtask

  // drive at negedge, one edge, return to next negedge
  task automatic step(input logic ls_i, lw_i, input logic [7:0] la_i, input logic ld_i,
                      input logic rs_i, rw_i, input logic [7:0] ra_i, input logic rd_i);
    ls = ls_i; lw = lw_i; la = la_i; ld = ld_i;
    rs = rs_i; rw = rw_i; ra = ra_i; rd = rd_i;
    if (ls && !lw) exp_l = (own[la[2:0]] == 1) ? 1'b0 : 1'b1;
    if (rs && !rw) exp_r = (own[ra[2:0]] == 2) ? 1'b0 : 1'b1;
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 8'h00, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic rd_both(input logic [7:0] a);
    step(1, 0, a, 0, 1, 0, a, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 8; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
    exp_l = 1; exp_r = 1;
    ls = 0; lw = 0; la = 0; ld = 0; rs = 0; rw = 0; ra = 0; rd = 0;
    rst_n = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R4 reset state
    chk("R4 reset left dout", l_dout, 1'b1);
    chk("R4 reset right dout", r_dout, 1'b1);
    rd_both(8'h00);
    chk("R4 free read left", l_dout, 1'b1);
    chk("R4 free read right", r_dout, 1'b1);

    // R2 / R5 left takes token 2
    step(1, 1, 8'h02, 0, 0, 0, 8'h00, 0);
    rd_both(8'h02);
    chk("R2 left granted", l_dout, 1'b0);
    chk("R5 other port reads 1", r_dout, 1'b1);

    // R3 right request while held: ownership unchanged
    step(0, 0, 8'h00, 0, 1, 1, 8'h02, 0);
    rd_both(8'h02);
    chk("R3 holder unchanged left", l_dout, 1'b0);
    chk("R3 holder unchanged right", r_dout, 1'b1);

    // R7 release hands to waiting right
    step(1, 1, 8'h02, 1, 0, 0, 8'h00, 0);
    rd_both(8'h02);
    chk("R7 handoff left", l_dout, 1'b1);
    chk("R7 handoff right", r_dout, 1'b0);

    // R6 release with none waiting frees
    step(0, 0, 8'h00, 0, 1, 1, 8'h02, 1);
    rd_both(8'h02);
    chk("R6 freed left", l_dout, 1'b1);
    chk("R6 freed right", r_dout, 1'b1);

    // R8 tie: left wins, right waits
    step(1, 1, 8'h05, 0, 1, 1, 8'h05, 0);
    rd_both(8'h05);
    chk("R8 tie left wins", l_dout, 1'b0);
    chk("R8 tie right loses", r_dout, 1'b1);
    step(1, 1, 8'h05, 1, 0, 0, 8'h00, 0);
    rd_both(8'h05);
    chk("R8 right request kept", r_dout, 1'b0);
    step(0, 0, 8'h00, 0, 1, 1, 8'h05, 1);

    // R7 release and request in same cycle
    step(1, 1, 8'h06, 0, 0, 0, 8'h00, 0);
    step(1, 1, 8'h06, 1, 1, 1, 8'h06, 0);
    rd_both(8'h06);
    chk("R7 same-cycle request granted", r_dout, 1'b0);
    step(0, 0, 8'h00, 0, 1, 1, 8'h06, 1);

    // R9 withdraw
    step(1, 1, 8'h01, 0, 0, 0, 8'h00, 0);
    step(0, 0, 8'h00, 0, 1, 1, 8'h01, 0);
    step(0, 0, 8'h00, 0, 1, 1, 8'h01, 1);
    step(1, 1, 8'h01, 1, 0, 0, 8'h00, 0);
    rd_both(8'h01);
    chk("R9 withdrawn left", l_dout, 1'b1);
    chk("R9 withdrawn right", r_dout, 1'b1);

    // R10 upper address bits ignored, tokens independent
    step(1, 1, 8'hF3, 0, 0, 0, 8'h00, 0);
    step(1, 0, 8'h03, 0, 1, 0, 8'h04, 0);
    chk("R10 alias to token 3", l_dout, 1'b0);
    chk("R10 token 4 untouched", r_dout, 1'b1);
    step(1, 0, 8'h04, 0, 0, 0, 8'h00, 0);
    chk("R10 token 4 free for left", l_dout, 1'b1);

    // R11 select low: no effect
    step(0, 1, 8'h07, 0, 0, 1, 8'h03, 1);
    step(1, 0, 8'h03, 0, 0, 0, 8'h00, 0);
    chk("R11 deselected release ignored", l_dout, 1'b0);
    step(0, 1, 8'h07, 0, 0, 1, 8'h07, 0);
    rd_both(8'h07);
    chk("R11 deselected request ignored L", l_dout, 1'b1);
    chk("R11 deselected request ignored R", r_dout, 1'b1);

    // R12 latency and hold
    step(1, 0, 8'h03, 0, 0, 0, 8'h00, 0);
    chk("R12 read after one cycle", l_dout, 1'b0);
    idle();
    chk("R12 held without read", l_dout, 1'b0);
    step(1, 1, 8'h03, 1, 0, 0, 8'h00, 0);
    chk("R12 held across write", l_dout, 1'b0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic a_s, a_w, a_d, b_s, b_w, b_d;
      logic [7:0] a_a, b_a;
      a_s = ($urandom % 4) != 0; a_w = $urandom % 2; a_d = $urandom % 2;
      b_s = ($urandom % 4) != 0; b_w = $urandom % 2; b_d = $urandom % 2;
      a_a = 8'($urandom % 4) | (8'($urandom % 2) << 6);
      b_a = 8'($urandom % 4) | (8'($urandom % 2) << 7);
      step(a_s, a_w, a_a, a_d, b_s, b_w, b_a, b_d);
      chk("R5 random left", l_dout, exp_l);
      chk("R12 random right", r_dout, exp_r);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule